// File: doc/BRIEF.md
# Instruction Control and Next-PC Decoder

This block is the combinational control unit of a single-cycle processor for a 32-bit instruction set. Every instruction is four bytes long and every format keeps its fields in the same bit positions. Each cycle the block receives the fetched instruction word, the current program counter and a flag from the datapath that says whether the two source registers are equal. In the same cycle it returns the register indices, the sign-extended immediate, the control signals that steer the datapath and the address of the next instruction.

The block recognises six operations: register add, add immediate, word load, word store, unconditional jump and branch-if-equal. Branches and jumps take effect on the next instruction, with no delay slot. Any other encoding is treated as a no-op. It writes nothing and the program counter moves on by four.

Top module: `insn_decode_npc`

## Requirements
- R1: `rs_idx`, `rt_idx` and `rd_idx` always equal instruction bits 25:21, 20:16 and 15:11, whatever the opcode.
- R2: `imm_ext` is instruction bits 15:0 sign-extended to 32 bits, so bit 15 is copied into bits 31:16.
- R3: Opcode (bits 31:26) 0 with function code (bits 5:0) 0x20 is register add. It asserts `reg_we` and `dst_sel_rd`, keeps `alu_src_imm`, `alu_sub`, `mem_rd`, `mem_we` and `wb_from_mem` low, and sets `next_pc` to `pc`+4.
- R4: Opcode 0x08 is add immediate. It asserts `reg_we` and `alu_src_imm`, keeps `dst_sel_rd` low so the rt field is the destination, keeps every other control low, and sets `next_pc` to `pc`+4.
- R5: Opcode 0x23 is word load. It asserts `mem_rd`, `wb_from_mem`, `reg_we` and `alu_src_imm`, keeps `dst_sel_rd`, `alu_sub` and `mem_we` low, and sets `next_pc` to `pc`+4.
- R6: Opcode 0x2B is word store. It asserts `mem_we` and `alu_src_imm`, keeps `reg_we`, `mem_rd`, `wb_from_mem`, `dst_sel_rd` and `alu_sub` low, and sets `next_pc` to `pc`+4.
- R7: Opcode 0x02 is jump. `next_pc` is `pc` bits 31:28, then instruction bits 25:0, then two zero bits. All control outputs are low.
- R8: Opcode 0x04 is branch-if-equal. It asserts `alu_sub` and keeps every other control low. `next_pc` is `pc`+4 plus `imm_ext` shifted left by 2 when `src_equal` is 1, and `pc`+4 when `src_equal` is 0.
- R9: Every other opcode, and opcode 0 with any function code other than 0x20, keeps all control outputs low and sets `next_pc` to `pc`+4.
- R10: When `pc` bits 1:0 are 00, `next_pc` bits 1:0 are 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Fetched instruction word |
| pc | input | 32 | Address of the current instruction |
| src_equal | input | 1 | Zero result of rs minus rt from the datapath |
| rs_idx | output | 5 | First source register index |
| rt_idx | output | 5 | Second source or immediate destination index |
| rd_idx | output | 5 | Register-format destination index |
| imm_ext | output | 32 | Sign-extended 16-bit immediate |
| dst_sel_rd | output | 1 | 1 selects rd as the write register, 0 selects rt |
| alu_src_imm | output | 1 | 1 selects the immediate as the second ALU operand |
| alu_sub | output | 1 | 1 makes the ALU subtract, 0 makes it add |
| reg_we | output | 1 | Register file write enable |
| mem_rd | output | 1 | Data memory read enable |
| mem_we | output | 1 | Data memory write enable |
| wb_from_mem | output | 1 | 1 writes back memory data, 0 writes back the ALU result |
| next_pc | output | 32 | Address of the next instruction |

## Verification
The directed cases are aimed at the places where a decoder usually goes wrong:
- Near-miss encodings, such as opcode 0 with function code 0x21. A decoder that keys on the opcode alone would write a register for these.
- Branches with negative and with maximum positive offsets. Leaving out the sign extension or the shift by two would send the program counter far off target.
- A jump from a program counter with non-zero upper bits. A target built without the top four bits would land in the wrong region.
- A branch with `src_equal` low, which must fall through to `pc`+4 and not take the branch.

Random instruction words with random fields, program counters and equality flags check that the field outputs and the sign extension hold for every opcode. They also check that no unrecognised opcode ever asserts a write enable.

// File: rtl/insn_decode_npc.sv
module insn_decode_npc #(
  parameter int XW = 32
) (
  input  logic [XW-1:0] instr,
  input  logic [XW-1:0] pc,
  input  logic          src_equal,
  output logic [4:0]    rs_idx,
  output logic [4:0]    rt_idx,
  output logic [4:0]    rd_idx,
  output logic [XW-1:0] imm_ext,
  output logic          dst_sel_rd,
  output logic          alu_src_imm,
  output logic          alu_sub,
  output logic          reg_we,
  output logic          mem_rd,
  output logic          mem_we,
  output logic          wb_from_mem,
  output logic [XW-1:0] next_pc
);
  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_LOAD = 6'h23;
  localparam logic [5:0] OP_STOR = 6'h2B;
  localparam logic [5:0] OP_JUMP = 6'h02;
  localparam logic [5:0] OP_BREQ = 6'h04;
  localparam logic [5:0] FN_ADD  = 6'h20;

  logic [5:0]    opc, fn;
  logic          is_jump, br_take;
  logic [XW-1:0] seq_pc, br_pc, jmp_pc;

  assign opc     = instr[31:26];
  assign fn      = instr[5:0];
  assign rs_idx  = instr[25:21];
  assign rt_idx  = instr[20:16];
  assign rd_idx  = instr[15:11];
  assign imm_ext = {{(XW-16){instr[15]}}, instr[15:0]};

  always_comb begin
    dst_sel_rd  = 1'b0;
    alu_src_imm = 1'b0;
    alu_sub     = 1'b0;
    reg_we      = 1'b0;
    mem_rd      = 1'b0;
    mem_we      = 1'b0;
    wb_from_mem = 1'b0;
    is_jump     = 1'b0;
    br_take     = 1'b0;
    case (opc)
      OP_REG: if (fn == FN_ADD) begin
        dst_sel_rd = 1'b1;
        reg_we     = 1'b1;
      end
      OP_ADDI: begin
        alu_src_imm = 1'b1;
        reg_we      = 1'b1;
      end
      OP_LOAD: begin
        alu_src_imm = 1'b1;
        reg_we      = 1'b1;
        mem_rd      = 1'b1;
        wb_from_mem = 1'b1;
      end
      OP_STOR: begin
        alu_src_imm = 1'b1;
        mem_we      = 1'b1;
      end
      OP_JUMP: is_jump = 1'b1;
      OP_BREQ: begin
        alu_sub = 1'b1;
        br_take = src_equal;
      end
      default: ;
    endcase
  end

  assign seq_pc  = pc + XW'(4);
  assign br_pc   = seq_pc + {imm_ext[XW-3:0], 2'b00};
  assign jmp_pc  = {pc[XW-1:XW-4], instr[25:0], 2'b00};
  assign next_pc = is_jump ? jmp_pc : (br_take ? br_pc : seq_pc);
endmodule

// File: rtl/insn_decode_npc_chk.sv
module insn_decode_npc_chk (
  input logic [31:0] instr,
  input logic [31:0] pc,
  input logic        src_equal,
  input logic        dst_sel_rd,
  input logic        reg_we,
  input logic        mem_rd,
  input logic        mem_we,
  input logic        wb_from_mem,
  input logic [31:0] next_pc
);
  always_comb begin
    if (!$isunknown({instr, pc, src_equal})) begin
      // R6
      store_no_regwrite_chk: assert (!(mem_we && reg_we));
      // R5
      load_writes_memdata_chk: assert (!mem_rd || (reg_we && wb_from_mem && !mem_we));
      // R3
      rd_only_for_regfmt_chk: assert (!dst_sel_rd || instr[31:26] == 6'h00);
      // R10
      pc_aligned_chk: assert (pc[1:0] != 2'b00 || next_pc[1:0] == 2'b00);
      // R9
      unknown_op_quiet_chk: assert (!(instr[31:26] inside {6'h01, 6'h03, 6'h05, 6'h3F})
                                    || (!reg_we && !mem_we && next_pc == pc + 32'd4));
    end
  end
endmodule

bind insn_decode_npc insn_decode_npc_chk u_chk (
  .instr(instr), .pc(pc), .src_equal(src_equal), .dst_sel_rd(dst_sel_rd),
  .reg_we(reg_we), .mem_rd(mem_rd), .mem_we(mem_we),
  .wb_from_mem(wb_from_mem), .next_pc(next_pc)
);

// File: tb/sim_insn_decode_npc.sv
module sim_insn_decode_npc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] instr = 32'd0, pc = 32'd0;
  logic        src_equal = 1'b0;
  logic [4:0]  rs_idx, rt_idx, rd_idx;
  logic [31:0] imm_ext, next_pc;
  logic        dst_sel_rd, alu_src_imm, alu_sub, reg_we, mem_rd, mem_we, wb_from_mem;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  insn_decode_npc u0 (
    .instr(instr), .pc(pc), .src_equal(src_equal),
    .rs_idx(rs_idx), .rt_idx(rt_idx), .rd_idx(rd_idx), .imm_ext(imm_ext),
    .dst_sel_rd(dst_sel_rd), .alu_src_imm(alu_src_imm), .alu_sub(alu_sub),
    .reg_we(reg_we), .mem_rd(mem_rd), .mem_we(mem_we),
    .wb_from_mem(wb_from_mem), .next_pc(next_pc)
  );

  // control vector order: dst_sel_rd, alu_src_imm, alu_sub, reg_we, mem_rd, mem_we, wb_from_mem
  function automatic logic [6:0] exp_ctl(input logic [31:0] w);
    case (w[31:26])
      6'h00:   return (w[5:0] == 6'h20) ? 7'b1001000 : 7'b0;
      6'h08:   return 7'b0101000;
      6'h23:   return 7'b0101101;
      6'h2B:   return 7'b0100010;
      6'h04:   return 7'b0010000;
      default: return 7'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_npc(input logic [31:0] w, input logic [31:0] p, input logic eq);
    logic [31:0] off;
    off = {{14{w[15]}}, w[15:0], 2'b00};
    if (w[31:26] == 6'h02) return {p[31:28], w[25:0], 2'b00};
    if (w[31:26] == 6'h04 && eq) return p + 32'd4 + off;
    return p + 32'd4;
  endfunction

  function automatic string req_of(input logic [31:0] w);
    case (w[31:26])
      6'h00:   return (w[5:0] == 6'h20) ? "R3" : "R9";
      6'h08:   return "R4";
      6'h23:   return "R5";
      6'h2B:   return "R6";
      6'h02:   return "R7";
      6'h04:   return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [31:0] w, input logic [31:0] p, input logic eq);
    logic [6:0] got;
    string r;
    @(negedge clk);
    instr = w; pc = p; src_equal = eq;
    #1;
    r = req_of(w);
    got = {dst_sel_rd, alu_src_imm, alu_sub, reg_we, mem_rd, mem_we, wb_from_mem};
    checks++;
    if ({rs_idx, rt_idx, rd_idx} !== {w[25:21], w[20:16], w[15:11]}) begin
      errors++;
      $display("FAIL R1 fields got %h expected %h", {rs_idx, rt_idx, rd_idx}, {w[25:21], w[20:16], w[15:11]});
    end
    checks++;
    if (imm_ext !== {{16{w[15]}}, w[15:0]}) begin
      errors++;
      $display("FAIL R2 imm got %h expected %h", imm_ext, {{16{w[15]}}, w[15:0]});
    end
    checks++;
    if (got !== exp_ctl(w)) begin
      errors++;
      $display("FAIL %s ctl instr %h got %b expected %b", r, w, got, exp_ctl(w));
    end
    checks++;
    if (next_pc !== exp_npc(w, p, eq)) begin
      errors++;
      $display("FAIL %s next_pc instr %h got %h expected %h", r, w, next_pc, exp_npc(w, p, eq));
    end
    checks++;
    if (p[1:0] == 2'b00 && next_pc[1:0] !== 2'b00) begin
      errors++;
      $display("FAIL R10 low pc bits got %b expected 00", next_pc[1:0]);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] ops [8];
    void'($urandom(32'd1234));
    ops = '{6'h00, 6'h08, 6'h23, 6'h2B, 6'h02, 6'h04, 6'h00, 6'h3F};
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: all-zero word is an unsupported function code (R9)
    apply(32'h0000_0000, 32'h0000_0000, 1'b0);
    // R3 add and near-miss function code (R9)
    apply({6'h00, 5'd3, 5'd4, 5'd5, 5'd0, 6'h20}, 32'h0040_0000, 1'b1);
    apply({6'h00, 5'd3, 5'd4, 5'd5, 5'd0, 6'h21}, 32'h0040_0000, 1'b1);
    // R2 sign boundary on R4
    apply({6'h08, 5'd1, 5'd2, 16'h8000}, 32'h0000_1000, 1'b0);
    apply({6'h08, 5'd1, 5'd2, 16'h7FFF}, 32'h0000_1000, 1'b0);
    // R5 and R6
    apply({6'h23, 5'd9, 5'd10, 16'hFFFC}, 32'h0000_2000, 1'b0);
    apply({6'h2B, 5'd9, 5'd10, 16'h0010}, 32'h0000_2000, 1'b1);
    // R7 upper pc bits kept
    apply({6'h02, 26'h3FF_FFFF}, 32'hA000_0010, 1'b0);
    apply({6'h02, 26'h000_0001}, 32'h5FFF_FFFC, 1'b1);
    // R8 taken negative, taken max positive, not taken
    apply({6'h04, 5'd1, 5'd2, 16'hFFFF}, 32'h0000_0100, 1'b1);
    apply({6'h04, 5'd1, 5'd2, 16'h7FFF}, 32'h0000_0100, 1'b1);
    apply({6'h04, 5'd1, 5'd2, 16'h0040}, 32'h0000_0100, 1'b0);
    // R9 pc wraps at top of space
    apply({6'h3F, 26'h155_5555}, 32'hFFFF_FFFC, 1'b1);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      w = $urandom;
      w[31:26] = ops[$urandom_range(0, 7)];
      if (w[31:26] == 6'h3F) w[31:26] = 6'($urandom);
      if ($urandom_range(0, 1) == 1 && w[31:26] == 6'h00) w[5:0] = 6'h20;
      apply(w, {$urandom, 2'b00} & 32'hFFFF_FFFC, 1'($urandom));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule